// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for every beat of a synchronous DRAM read or write burst. When a command is issued it captures the starting column together with a three-bit burst length code and a one-bit ordering select, and from the next clock onward it presents one column address per cycle until the burst is complete. The controller that surrounds it uses the address stream to drive the column pins beat by beat. Data transfer, data masking and read latency are handled elsewhere.

Two orderings are supported. In sequential ordering the column counts upward and wraps inside the aligned block whose size is the burst length. In interleave ordering the low bits of each beat are the start bits XOR the beat number. A whole-row mode, allowed only with sequential ordering, keeps counting modulo the row size until it is stopped or replaced by a new command. A stop input ends a burst early, and a suspend input freezes the sequence in place. The final beat of every finite burst is flagged, and codes that have no defined meaning raise an error flag and fall back to a single beat.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `beat_valid`, `last_beat` and `mode_err` are low, and stay low until a command is accepted.
- R2: Length code `len_code` 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats; 3'b111 with `ilv`=0 gives a whole-row burst of unbounded length.
- R3: With `ilv`=0 and a finite length L, beat k has address `(s - s mod L) + ((s mod L + k) mod L)` for start column s.
- R4: With `ilv`=1 and a finite length L, beat k has address `(s - s mod L) + ((s mod L) XOR k)`.
- R5: A whole-row burst gives address `(s + k) mod 256` for beat k, never asserts `last_beat`, and runs until `stop` or a new `start`.
- R6: Codes 3'b100, 3'b101, 3'b110, and 3'b111 with `ilv`=1, are reserved: the burst is a single beat at the start column with `mode_err` and `last_beat` high on that beat.
- R7: `last_beat` is high exactly on the final beat of a finite burst, and `beat_valid` is low in the cycle after it unless a new command arrives.
- R8: `stop` sampled high on a clock edge while a burst runs (with `start` and `hold` low) makes `beat_valid` low after that edge.
- R9: While `hold` is high on a clock edge, the address, beat position, `beat_valid` and `last_beat` keep their values, and `start` and `stop` on that edge are ignored.
- R10: `start` sampled during a running burst begins the new burst at once with its own parameters, and takes precedence over `stop` on the same edge.
- R11: The first beat, equal to the start column, appears in the cycle after the edge on which `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command issue: capture column, length code and ordering |
| start_col | input | 8 | Starting column of the burst |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | Ordering select: 0 sequential, 1 interleave |
| stop | input | 1 | Terminate the running burst |
| hold | input | 1 | Clock suspend: freeze the sequence |
| col_addr | output | 8 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final beat of a finite burst |
| mode_err | output | 1 | Current burst was started with a reserved code |

## Verification
The embedded properties assume that `start`, `stop` and `hold` are clean single-bit levels changed only away from the rising edge, and that `start_col`, `len_code` and `ilv` are steady whenever `start` is sampled. The bench drives every input on the falling edge and releases `start` and `stop` after one cycle, so each command is seen on exactly one edge. It sweeps every start column against every length code and both orderings, and whole-row bursts are swept on a spaced subset of start columns long enough to cross the 256-column wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LC_ONE  = 3'b000,
        LC_TWO  = 3'b001,
        LC_FOUR = 3'b010,
        LC_EGHT = 3'b011,
        LC_ROW  = 3'b111
    } len_code_e;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  ilv_i,
    output logic [COL_W-1:0]      wrap_mask_o,
    output logic                  row_mode_o,
    output logic                  reserved_o
);

    always_comb begin
        wrap_mask_o = '0;
        row_mode_o  = 1'b0;
        reserved_o  = 1'b0;
        case (code_i)
            LC_ONE:  wrap_mask_o = COL_W'(0);
            LC_TWO:  wrap_mask_o = COL_W'(1);
            LC_FOUR: wrap_mask_o = COL_W'(3);
            LC_EGHT: wrap_mask_o = COL_W'(7);
            LC_ROW: begin
                if (ilv_i) begin
                    reserved_o = 1'b1;
                end else begin
                    wrap_mask_o = '1;
                    row_mode_o  = 1'b1;
                end
            end
            default: reserved_o = 1'b1;
        endcase
    end

    // R6: a reserved code never yields a multi-beat window
    always_comb begin
        a_r6_reserved_single: assert (!reserved_o || (wrap_mask_o == '0 && !row_mode_o));
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] addr_o
);

    logic [COL_W-1:0] sum;

    // Carries leaving the masked window are discarded bit by bit below.
    assign sum = base_i + beat_i;

    generate
        for (genvar b = 0; b < COL_W; b++) begin : g_bit
            logic inner;
            assign inner     = ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b];
            assign addr_o[b] = wrap_mask_i[b] ? inner : base_i[b];
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  ilv,
    input  logic                  stop,
    input  logic                  hold,
    output logic [COL_W-1:0]      col_addr,
    output logic                  beat_valid,
    output logic                  last_beat,
    output logic                  mode_err
);

    typedef struct packed {
        logic             active;
        logic             ilv;
        logic             row;
        logic             err;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_row;
    logic             dec_res;
    logic             final_q;

    burst_mode_dec #(.COL_W(COL_W)) u_dec (
        .code_i      (len_code),
        .ilv_i       (ilv),
        .wrap_mask_o (dec_mask),
        .row_mode_o  (dec_row),
        .reserved_o  (dec_res)
    );

    burst_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_i      (st_q.base),
        .beat_i      (st_q.cnt),
        .wrap_mask_i (st_q.mask),
        .ilv_i       (st_q.ilv),
        .addr_o      (col_addr)
    );

    // Finite bursts end when the beat index reaches the window mask (length - 1).
    assign final_q = !st_q.row && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.base   = start_col;
                st_d.cnt    = '0;
                st_d.mask   = dec_mask;
                st_d.ilv    = ilv;
                st_d.row    = dec_row;
                st_d.err    = dec_res;
            end else if (st_q.active) begin
                if (stop || final_q) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid = st_q.active;
    assign last_beat  = st_q.active && final_q;
    assign mode_err   = st_q.active && st_q.err;

    // R1: the flags only ever qualify a live beat
    a_r1_flags_need_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat || mode_err) |-> beat_valid);

    // R11: the first beat follows an accepted command and carries its column
    a_r11_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hold) |=> (beat_valid && col_addr == $past(start_col)));

    // R7: the burst closes after its final beat
    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !start && !hold) |=> !beat_valid);

    // R8: a stop ends the running burst on the next edge
    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && stop && !start && !hold) |=> !beat_valid);

    // R9: suspend freezes the visible sequence
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(beat_valid) && $stable(col_addr) && $stable(last_beat)));

    // R6: a reserved code produces exactly one beat
    a_r6_err_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> last_beat);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ilv = 1'b0;
    logic       stop = 1'b0;
    logic       hold = 1'b0;
    logic [7:0] col_addr;
    logic       beat_valid;
    logic       last_beat;
    logic       mode_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    burst_col_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .len_code   (len_code),
        .ilv        (ilv),
        .stop       (stop),
        .hold       (hold),
        .col_addr   (col_addr),
        .beat_valid (beat_valid),
        .last_beat  (last_beat),
        .mode_err   (mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int s, input int k, input int len, input bit il);
        int off;
        off = s % len;
        if (len >= 256) return (s + k) % 256;
        if (il) return (s - off) + (off ^ k);
        return (s - off) + ((off + k) % len);
    endfunction

    // Issue a command on the next edge; returns positioned on the first beat.
    task automatic issue(input int s, input int code, input bit il);
        @(negedge clk);
        start     = 1'b1;
        start_col = 8'(s);
        len_code  = 3'(code);
        ilv       = il;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_finite(input int s, input int code, input bit il);
        int  len;
        bit  res;
        res = (code > 3) || (code == 7 && il);
        len = res ? 1 : (1 << code);
        issue(s, code, il);
        for (int k = 0; k < len; k++) begin
            int e;
            e = exp_addr(s, k, len, il);
            if (il) chk(beat_valid && col_addr == 8'(e), "R4", int'(col_addr), e);
            else    chk(beat_valid && col_addr == 8'(e), "R3", int'(col_addr), e);
            chk(last_beat == (k == len - 1), "R7", int'(last_beat), int'(k == len - 1));
            chk(mode_err == res, "R6", int'(mode_err), int'(res));
            if (k + 1 < len) @(negedge clk);
        end
        @(negedge clk);
        chk(!beat_valid, "R2", int'(beat_valid), 0);
    endtask

    task automatic run_row(input int s, input int beats);
        issue(s, 7, 1'b0);
        for (int k = 0; k < beats; k++) begin
            int e;
            e = (s + k) % 256;
            chk(beat_valid && col_addr == 8'(e) && !last_beat && !mode_err, "R5",
                int'(col_addr), e);
            if (k == beats - 1) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        chk(!beat_valid, "R8", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!beat_valid && !last_beat && !mode_err, "R1",
            int'({beat_valid, last_beat, mode_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !last_beat && !mode_err, "R1",
            int'({beat_valid, last_beat, mode_err}), 0);

        // R2 R3 R4 R6 R7: every column against every code and ordering
        for (int code = 0; code < 8; code++) begin
            for (int il = 0; il < 2; il++) begin
                if (code == 7 && il == 0) continue;
                for (int s = 0; s < 256; s++) run_finite(s, code, il[0]);
            end
        end

        // R5: whole-row bursts across the wrap point
        for (int s = 0; s < 256; s += 17) run_row(s, 262);

        // R8: early stop of a finite burst
        issue(8'h2C, 3, 1'b0);
        repeat (3) @(negedge clk);
        chk(col_addr == 8'h2F && beat_valid, "R8", int'(col_addr), 8'h2F);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!beat_valid, "R8", int'(beat_valid), 0);

        // R9: suspend mid-burst; start and stop during it are ignored
        issue(3, 3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk(col_addr == 8'd5, "R9", int'(col_addr), 5);
        hold = 1'b1; start = 1'b1; stop = 1'b1; start_col = 8'h90; len_code = 3'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(beat_valid && col_addr == 8'd5 && !last_beat, "R9", int'(col_addr), 5);
        end
        hold = 1'b0; start = 1'b0; stop = 1'b0;
        for (int k = 3; k < 8; k++) begin
            @(negedge clk);
            chk(beat_valid && col_addr == 8'(exp_addr(3, k, 8, 1'b0)), "R9",
                int'(col_addr), exp_addr(3, k, 8, 1'b0));
        end
        chk(last_beat, "R7", int'(last_beat), 1);
        @(negedge clk);
        chk(!beat_valid, "R7", int'(beat_valid), 0);

        // R10: new command mid-burst beats a simultaneous stop
        issue(0, 3, 1'b0);
        @(negedge clk);
        start = 1'b1; stop = 1'b1; start_col = 8'h41; len_code = 3'd1; ilv = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(beat_valid && col_addr == 8'h41, "R10", int'(col_addr), 8'h41);
        chk(!last_beat, "R10", int'(last_beat), 0);
        @(negedge clk);
        chk(beat_valid && col_addr == 8'h40 && last_beat, "R10", int'(col_addr), 8'h40);
        @(negedge clk);
        chk(!beat_valid, "R10", int'(beat_valid), 0);

        // R11: first beat exactly one cycle after the command edge
        @(negedge clk);
        start = 1'b1; start_col = 8'hE6; len_code = 3'd2; ilv = 1'b0;
        @(posedge clk);
        #1;
        chk(beat_valid && col_addr == 8'hE6, "R11", int'(col_addr), 8'hE6);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule